// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a 32-bit load/store pipeline stage. A request names an addressing mode, an operand size, a 4-bit displacement and a base register index. The block reads the base register and a fixed index register (register 0) from a 16-entry register file that it owns. One clock later it returns the effective address. For the pre-decrement mode it also returns the updated base register value, which it writes into the register file on that same clock edge.

Three modes are legal. Pre-decrement lowers the base register by the operand size and uses the lowered value as the address. Displacement adds an unsigned, size-scaled 4-bit offset to the base register. Indexed adds register 0 to the base register. Any other combination is flagged as illegal, and the block does not change its register file for it. A separate load port writes any register, so that a producer elsewhere in the pipeline can fill the register file.

Top module: `lsu_agen`

## Requirements
- R1: `valid_out` is high exactly in the cycle after a cycle in which `valid_in` was high, and low in every other cycle.
- R2: With `mode` 2'b00 (pre-decrement), `wb_data` is the base register minus a step. The step is 1, 2, 4 or 8 for `size` 2'b00, 2'b01, 2'b10 or 2'b11. `wb_en` is high and the base register holds this value from that edge on.
- R3: In pre-decrement, `ea` equals the decremented value (`wb_data`) and not the old register value.
- R4: With `mode` 2'b01 (displacement) and `size` below 2'b11, `ea` is the base register plus the zero-extended `disp`. The offset is multiplied by 1, 2 or 4 for byte, word or longword.
- R5: With `mode` 2'b10 (indexed), `ea` is the base register plus register 0, with no scaling.
- R6: All address arithmetic wraps modulo 2^32 and raises no flag.
- R7: Displacement with `size` 2'b11, and `mode` 2'b11 at any size, set `illegal_mode` high, force `ea` to zero and keep `wb_en` low.
- R8: Displacement, indexed and illegal requests leave every register unchanged.
- R9: A pre-decrement whose base is register 0 decrements and writes register 0, and `wb_idx` reports 0.
- R10: After reset, `valid_out`, `wb_en` and `illegal_mode` are low, and every register reads zero.
- R11: A write on the load port is visible to a request in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Request strobe |
| mode | input | 2 | 00 pre-decrement, 01 displacement, 10 indexed, 11 reserved |
| size | input | 2 | 00 byte, 01 word, 10 longword, 11 quadword |
| disp | input | 4 | Unsigned displacement |
| base_idx | input | 4 | Base register index |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 4 | Register load index |
| ld_data | input | 32 | Register load value |
| valid_out | output | 1 | Result strobe, one cycle after request |
| ea | output | 32 | Effective address |
| illegal_mode | output | 1 | Request combination not supported |
| wb_en | output | 1 | Base register was written back |
| wb_idx | output | 4 | Index of the written register |
| wb_data | output | 32 | Value written back |

## Verification
The assertions assume that the load port is never driven in the same cycle as a request. With that assumption, the register value a request reads is the one left by the previous edge. The bench applies loads only in cycles with no request and always waits for a result before it loads again. The sweep covers every mode, size, displacement and base register. It runs on register contents that earlier pre-decrements keep changing, including values near zero and near 2^32.

// File: rtl/lsu_agen_pkg.sv
package lsu_agen_pkg;
   typedef enum logic [1:0] {
      AM_PREDEC = 2'd0,
      AM_DISP   = 2'd1,
      AM_INDEX  = 2'd2,
      AM_RSVD   = 2'd3
   } amode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_QUAD = 2'd3
   } osize_e;
endpackage

// File: rtl/lsu_agen_calc.sv
module lsu_agen_calc
   import lsu_agen_pkg::*;
#(
   parameter int AW    = 32,
   parameter int DISPW = 4
) (
   input  logic [1:0]       mode,
   input  logic [1:0]       size,
   input  logic [DISPW-1:0] disp,
   input  logic [AW-1:0]    base_val,
   input  logic [AW-1:0]    idx_val,
   output logic [AW-1:0]    ea,
   output logic             wb_en,
   output logic [AW-1:0]    wb_data,
   output logic             illegal
);
   logic [AW-1:0] step;
   logic [AW-1:0] offset;
   logic [AW-1:0] lowered;

   always_comb begin
      step    = AW'(1) << size;
      offset  = AW'(disp) << size;
      lowered = base_val - step;
   end

   always_comb begin
      ea      = '0;
      wb_en   = 1'b0;
      wb_data = lowered;
      illegal = 1'b0;
      case (amode_e'(mode))
         AM_PREDEC: begin
            ea    = lowered;
            wb_en = 1'b1;
         end
         AM_DISP: begin
            if (osize_e'(size) == SZ_QUAD) illegal = 1'b1;
            else                           ea      = base_val + offset;
         end
         AM_INDEX: ea = base_val + idx_val;
         default:  illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/lsu_agen_regfile.sv
module lsu_agen_regfile #(
   parameter int AW      = 32,
   parameter int NREG    = 16,
   parameter int IDX_REG = 0,
   localparam int RW     = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [RW-1:0] rd_idx,
   output logic [AW-1:0] rd_data,
   output logic [AW-1:0] ix_data,
   input  logic          wa_en,
   input  logic [RW-1:0] wa_idx,
   input  logic [AW-1:0] wa_data,
   input  logic          wb_en,
   input  logic [RW-1:0] wb_idx,
   input  logic [AW-1:0] wb_data
);
   logic [AW-1:0] regs [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [AW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                q <= '0;
         else if (wa_en && wa_idx == RW'(g))        q <= wa_data;
         else if (wb_en && wb_idx == RW'(g))        q <= wb_data;
      end
      assign regs[g] = q;
   end

   assign rd_data = regs[rd_idx];
   assign ix_data = regs[IDX_REG];
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen
   import lsu_agen_pkg::*;
#(
   parameter int AW      = 32,
   parameter int NREG    = 16,
   parameter int DISPW   = 4,
   parameter int IDX_REG = 0,
   localparam int RW     = $clog2(NREG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_in,
   input  logic [1:0]       mode,
   input  logic [1:0]       size,
   input  logic [DISPW-1:0] disp,
   input  logic [RW-1:0]    base_idx,
   input  logic             ld_en,
   input  logic [RW-1:0]    ld_idx,
   input  logic [AW-1:0]    ld_data,
   output logic             valid_out,
   output logic [AW-1:0]    ea,
   output logic             illegal_mode,
   output logic             wb_en,
   output logic [RW-1:0]    wb_idx,
   output logic [AW-1:0]    wb_data
);
   if (AW < 8) begin : g_bad_aw
      $error("lsu_agen: AW must be at least 8");
   end
   if (NREG < 2 || NREG != (1 << RW)) begin : g_bad_nreg
      $error("lsu_agen: NREG must be a power of two of at least 2");
   end
   if (IDX_REG >= NREG) begin : g_bad_idx
      $error("lsu_agen: IDX_REG out of range");
   end
   if (DISPW < 1 || DISPW + 3 > AW) begin : g_bad_disp
      $error("lsu_agen: DISPW out of range");
   end

   logic [AW-1:0] base_rd;
   logic [AW-1:0] idx_rd;
   logic [AW-1:0] c_ea;
   logic [AW-1:0] c_wbd;
   logic          c_wbe;
   logic          c_ill;
   logic          do_wb;

   lsu_agen_regfile #(.AW(AW), .NREG(NREG), .IDX_REG(IDX_REG)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (base_idx),
      .rd_data (base_rd),
      .ix_data (idx_rd),
      .wa_en   (ld_en),
      .wa_idx  (ld_idx),
      .wa_data (ld_data),
      .wb_en   (do_wb),
      .wb_idx  (base_idx),
      .wb_data (c_wbd)
   );

   lsu_agen_calc #(.AW(AW), .DISPW(DISPW)) u_calc (
      .mode     (mode),
      .size     (size),
      .disp     (disp),
      .base_val (base_rd),
      .idx_val  (idx_rd),
      .ea       (c_ea),
      .wb_en    (c_wbe),
      .wb_data  (c_wbd),
      .illegal  (c_ill)
   );

   assign do_wb = valid_in && c_wbe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_out    <= 1'b0;
         ea           <= '0;
         illegal_mode <= 1'b0;
         wb_en        <= 1'b0;
         wb_idx       <= '0;
         wb_data      <= '0;
      end else begin
         valid_out    <= valid_in;
         illegal_mode <= valid_in && c_ill;
         wb_en        <= do_wb;
         if (valid_in) begin
            ea      <= c_ea;
            wb_idx  <= base_idx;
            wb_data <= c_wbd;
         end
      end
   end
endmodule

// File: rtl/lsu_agen_chk.sv
module lsu_agen_chk #(
   parameter int AW = 32,
   parameter int RW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          valid_in,
   input logic [1:0]    mode,
   input logic [1:0]    size,
   input logic [RW-1:0] base_idx,
   input logic [AW-1:0] base_rd,
   input logic          valid_out,
   input logic [AW-1:0] ea,
   input logic          illegal_mode,
   input logic          wb_en,
   input logic [RW-1:0] wb_idx,
   input logic [AW-1:0] wb_data
);
   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);                                             // R1
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> !valid_out);                                           // R1
   AST_PREDEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && mode == 2'b00) |=>
         (wb_en && wb_data == $past(base_rd) - (AW'(1) << $past(size))));  // R2
   AST_EA_IS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> (ea == wb_data && valid_out));                             // R3
   AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_mode |-> (!wb_en && ea == '0 && valid_out));                 // R7
   AST_NONPREDEC_NOWB: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && mode != 2'b00) |=> !wb_en);                             // R8
   AST_WB_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && mode == 2'b00) |=> (wb_idx == $past(base_idx)));        // R9
endmodule

bind lsu_agen lsu_agen_chk #(.AW(AW), .RW(RW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .valid_in     (valid_in),
   .mode         (mode),
   .size         (size),
   .base_idx     (base_idx),
   .base_rd      (base_rd),
   .valid_out    (valid_out),
   .ea           (ea),
   .illegal_mode (illegal_mode),
   .wb_en        (wb_en),
   .wb_idx       (wb_idx),
   .wb_data      (wb_data)
);

// File: tb/lsu_agen_tb.sv
`timescale 1ns/1ps
module lsu_agen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_in = 1'b0;
   logic [1:0]  mode = '0;
   logic [1:0]  size = '0;
   logic [3:0]  disp = '0;
   logic [3:0]  base_idx = '0;
   logic        ld_en = 1'b0;
   logic [3:0]  ld_idx = '0;
   logic [31:0] ld_data = '0;
   logic        valid_out;
   logic [31:0] ea;
   logic        illegal_mode;
   logic        wb_en;
   logic [3:0]  wb_idx;
   logic [31:0] wb_data;

   int n_run = 0;
   int n_fail = 0;
   logic [31:0] m [16];

   always #2 clk = ~clk;

   lsu_agen u_dut (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .mode(mode), .size(size),
      .disp(disp), .base_idx(base_idx), .ld_en(ld_en), .ld_idx(ld_idx),
      .ld_data(ld_data), .valid_out(valid_out), .ea(ea),
      .illegal_mode(illegal_mode), .wb_en(wb_en), .wb_idx(wb_idx),
      .wb_data(wb_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   task automatic load(input logic [3:0] idx, input logic [31:0] val);
      @(negedge clk);
      ld_en = 1'b1; ld_idx = idx; ld_data = val;
      @(negedge clk);
      ld_en = 1'b0;
      m[idx] = val;
   endtask

   task automatic op(input logic [1:0] md, input logic [1:0] sz, input logic [3:0] dp,
                     input logic [3:0] bi, input string tag);
      logic [31:0] e_ea;
      logic [31:0] e_wbd;
      logic        e_ill;
      logic        e_wb;
      e_wbd = m[bi] - (32'd1 << sz);
      e_ill = (md == 2'b11) || (md == 2'b01 && sz == 2'b11);
      e_wb  = (md == 2'b00);
      case (md)
         2'b00:   e_ea = e_wbd;
         2'b01:   e_ea = e_ill ? 32'd0 : m[bi] + ({28'd0, dp} << sz);
         2'b10:   e_ea = m[bi] + m[0];
         default: e_ea = 32'd0;
      endcase
      @(negedge clk);
      valid_in = 1'b1; mode = md; size = sz; disp = dp; base_idx = bi;
      @(negedge clk);
      valid_in = 1'b0;
      chk({valid_out, illegal_mode, wb_en, ea} == {1'b1, e_ill, e_wb, e_ea}, tag,
          {29'd0, valid_out, illegal_mode, wb_en, ea},
          {29'd0, 1'b1, e_ill, e_wb, e_ea});
      if (e_wb) begin
         chk({wb_idx, wb_data} == {bi, e_wbd}, tag, {28'd0, wb_idx, wb_data},
             {28'd0, bi, e_wbd});
         m[bi] = e_wbd;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      for (int i = 0; i < 16; i++) m[i] = 32'd0;
      repeat (3) @(negedge clk);
      chk({valid_out, wb_en, illegal_mode} == 3'b000, "R10 reset outputs",
          {61'd0, valid_out, wb_en, illegal_mode}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      op(2'b10, 2'b10, 4'd0, 4'd7, "R10 registers zero after reset");
      @(negedge clk);
      chk(valid_out == 1'b0, "R1 idle cycle", {63'd0, valid_out}, 64'd0);

      for (int i = 0; i < 16; i++) load(4'(i), 32'h0100_0000 * i + 32'h40 * i);
      load(4'd0, 32'h0000_0100);
      op(2'b10, 2'b00, 4'd0, 4'd6, "R11 load then read");
      load(4'd3, 32'd0);
      op(2'b00, 2'b00, 4'd0, 4'd3, "R6 pre-decrement wrap");
      op(2'b10, 2'b00, 4'd0, 4'd3, "R2 written back value");
      load(4'd4, 32'hFFFF_FFF8);
      op(2'b10, 2'b11, 4'd9, 4'd4, "R6 indexed wrap");
      load(4'd5, 32'hFFFF_FFFE);
      op(2'b01, 2'b10, 4'd15, 4'd5, "R6 displacement wrap");
      op(2'b01, 2'b00, 4'd15, 4'd5, "R4 max displacement unsigned");
      op(2'b00, 2'b10, 4'd0, 4'd0, "R9 base register 0");
      op(2'b10, 2'b00, 4'd0, 4'd0, "R9 register 0 updated");
      op(2'b00, 2'b11, 4'd0, 4'd2, "R3 address is new value");
      op(2'b01, 2'b11, 4'd3, 4'd2, "R7 displacement quadword");
      op(2'b11, 2'b01, 4'd3, 4'd2, "R7 reserved mode");
      op(2'b10, 2'b00, 4'd0, 4'd2, "R8 unchanged after illegal");
      @(negedge clk);
      chk(valid_out == 1'b0, "R1 idle after burst", {63'd0, valid_out}, 64'd0);

      for (int md = 0; md < 4; md++)
         for (int sz = 0; sz < 4; sz++)
            for (int dp = 0; dp < 16; dp++)
               for (int bi = 0; bi < 16; bi++)
                  op(2'(md), 2'(sz), 4'(dp), 4'(bi),
                     md == 0 ? (bi == 0 ? "R9 sweep pre-decrement" : "R2 sweep pre-decrement") :
                     md == 1 ? (sz == 3 ? "R7 sweep illegal" : "R4 sweep displacement") :
                     md == 2 ? "R5 sweep indexed" : "R7 sweep reserved");
      for (int bi = 0; bi < 16; bi++)
         op(2'b10, 2'b00, 4'd0, 4'(bi), "R8 final register contents");
      summary();
   end
endmodule